// File: doc/BRIEF.md
# T-1 Framing Elastic Buffer

This block sits between a switch core that moves 192 payload bits per 125 µs frame (24 slots of 8 bits, 1.536 Mb/s) and a T-1 line that carries 193 bits per frame (1.544 Mb/s). It has a transmit path and a receive path. Each path has its own bit-wide elastic store. Both ports run on one clock and are paced by enable strobes.

On transmit, the core writes payload bits in slot order, most significant bit first. The line side serializes one bit per line strobe. Each frame starts with a framing bit taken from a 12-frame pattern parameter, followed by 192 payload bits. This insertion makes the line rate higher than the write rate, and the store absorbs the difference. On receive, line bits are written into the store, except the bit that an external framer marks as the framing bit. The core then reads the bits at its own pace, which absorbs short-term jitter.

Neither store releases data until it holds a preset number of bits. If a write reaches a full store, or a read reaches an empty store, the store recentres and reports a one-cycle event. A sticky slip flag records that such an event has occurred.

Top module: `t1eb_top`

## Requirements
- R1: While reset is asserted, and until the first enabled event after reset, every output is 0.
- R2: After the serializer starts, the line output is valid in the cycle after each `tx_line_en` strobe. Every frame is 193 bits long: one framing bit, marked by `tx_frame_start`, then 192 bits taken from the transmit store in write order.
- R3: The framing bit of line frame k (k = 0 for the first frame after reset) equals bit (k mod 12) of parameter `FBIT_PAT`.
- R4: The serializer starts on the first line strobe at which the transmit store has reached `PREFILL` bits. Until then `tx_line_valid` stays 0, and the first valid line bit is a framing bit.
- R5: In a payload position, if the transmit store is prefilling or empty, the line bit is 1.
- R6: A receive line bit is stored only when `rx_line_fbit` is 0. Stored bits come out on `rx_bit`, in arrival order, with `rx_valid` = 1 in the cycle after an `rx_rd_en` that finds data available.
- R7: A store releases no data and raises no underflow until it holds `PREFILL` bits. Read strobes during this prefill have no effect.
- R8: A write to a full store (2**`ADDR_W` bits) with no read in the same cycle drops the incoming bit and keeps only the newest `PREFILL` bits. It also pulses the overflow output for that path in the next cycle.
- R9: A read strobe on an empty store that has finished prefilling pulses the underflow output in the next cycle. The store then returns to prefill.
- R10: `slip_sticky` rises with the first overflow or underflow pulse on either path and stays at 1 until reset.
- R11: If a read and a write fall in the same cycle on a full store, there is no overflow. If they fall in the same cycle on an empty, prefilled store, the read underflows and the written bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Core writes one transmit bit |
| tx_wr_bit | input | 1 | Transmit payload bit |
| tx_line_en | input | 1 | Line bit strobe for transmit |
| tx_line_bit | output | 1 | Serialized line bit |
| tx_line_valid | output | 1 | Line bit valid |
| tx_frame_start | output | 1 | Current line bit is the framing bit |
| rx_line_en | input | 1 | Received line bit strobe |
| rx_line_bit | input | 1 | Received line bit |
| rx_line_fbit | input | 1 | Strobed bit is the framing bit; do not store |
| rx_rd_en | input | 1 | Core reads one receive bit |
| rx_bit | output | 1 | Receive payload bit |
| rx_valid | output | 1 | Receive bit valid |
| tx_ovf | output | 1 | Transmit store overflow pulse |
| tx_unf | output | 1 | Transmit store underflow pulse |
| rx_ovf | output | 1 | Receive store overflow pulse |
| rx_unf | output | 1 | Receive store underflow pulse |
| slip_sticky | output | 1 | Any slip since reset |

## Verification
A write and a read can land on the same store in the same cycle while it is exactly full or exactly empty. At full the read must cancel the overflow. At empty the read must underflow and the write must still be kept. A phase of dense, equal-probability random strobes on both sides of each store drives the fill level repeatedly to both limits, so these coincidences occur many times. Every clock, the outputs are judged against a queue-based model that applies the read before the overflow decision and the write after the underflow decision. Slower phases, either write-heavy or read-heavy, reach each limit with only one side active.

// File: rtl/t1eb_pkg.sv
package t1eb_pkg;
  localparam int SLOTS     = 24;
  localparam int SLOT_BITS = 8;
  localparam int DATA_BITS = SLOTS * SLOT_BITS;
  localparam int LINE_BITS = DATA_BITS + 1;

  typedef struct packed {
    logic ovf;
    logic unf;
  } elastic_ev_t;
endpackage

// File: rtl/t1eb_elastic.sv
module t1eb_elastic
  import t1eb_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PREFILL = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_bit,
  input  logic        rd_en,
  output logic        rd_bit,
  output logic        primed,
  output logic        empty,
  output elastic_ev_t ev
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = ADDR_W + 1;
  localparam logic [CW-1:0]     FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0]     PF_C   = CW'(PREFILL);
  localparam logic [ADDR_W-1:0] PF_A   = ADDR_W'(PREFILL);

  logic [DEPTH-1:0]  mem;
  logic [ADDR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              prm_q, prm_d;
  logic              do_rd, do_wr, full;

  always_comb begin
    empty  = (cnt_q == '0);
    full   = (cnt_q == FULL_C);
    do_rd  = rd_en & prm_q & ~empty;
    ev.unf = rd_en & prm_q & empty;
    ev.ovf = wr_en & full & ~do_rd;
    do_wr  = wr_en & ~ev.ovf;
    wp_d   = do_wr ? wp_q + 1'b1 : wp_q;
    if (ev.ovf) begin
      rp_d  = wp_q - PF_A;
      cnt_d = PF_C;
    end else begin
      rp_d  = do_rd ? rp_q + 1'b1 : rp_q;
      cnt_d = cnt_q + CW'(do_wr) - CW'(do_rd);
    end
    prm_d  = ev.unf ? 1'b0 : (prm_q | (cnt_d >= PF_C));
    rd_bit = mem[rp_q];
    primed = prm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      prm_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      prm_q <= prm_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (do_wr && (wp_q == ADDR_W'(i))) mem[i] <= wr_bit;
    end
  end
endmodule

// File: rtl/t1eb_tx_framer.sv
module t1eb_tx_framer
  import t1eb_pkg::*;
#(
  parameter int                DBITS  = DATA_BITS,
  parameter int                MF_LEN = 12,
  parameter logic [MF_LEN-1:0] FPAT   = 12'b1000_1101_1100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_en,
  input  logic fifo_primed,
  input  logic fifo_empty,
  input  logic fifo_bit,
  output logic fifo_rd,
  output logic line_bit,
  output logic line_valid,
  output logic frame_start
);
  localparam int LBITS = DBITS + 1;
  localparam int PW    = $clog2(LBITS);
  localparam int FW    = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(LBITS - 1);
  localparam logic [FW-1:0] MF_LAST  = FW'(MF_LEN - 1);

  logic          started_q, started_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [FW-1:0] fidx_q, fidx_d;
  logic          bit_q, bit_d, val_q, val_d, fs_q, fs_d;
  logic          emit, is_f;

  always_comb begin
    emit      = line_en & (started_q | fifo_primed);
    is_f      = (pos_q == '0);
    fifo_rd   = emit & ~is_f;
    started_d = started_q | emit;
    pos_d     = pos_q;
    fidx_d    = fidx_q;
    if (emit) begin
      pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      if (is_f) fidx_d = (fidx_q == MF_LAST) ? '0 : fidx_q + 1'b1;
    end
    val_d = emit;
    fs_d  = emit & is_f;
    if (!emit)      bit_d = 1'b0;
    else if (is_f)  bit_d = FPAT[fidx_q];
    else            bit_d = (fifo_primed & ~fifo_empty) ? fifo_bit : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pos_q     <= '0;
      fidx_q    <= '0;
      bit_q     <= 1'b0;
      val_q     <= 1'b0;
      fs_q      <= 1'b0;
    end else begin
      started_q <= started_d;
      pos_q     <= pos_d;
      fidx_q    <= fidx_d;
      bit_q     <= bit_d;
      val_q     <= val_d;
      fs_q      <= fs_d;
    end
  end

  assign line_bit    = bit_q;
  assign line_valid  = val_q;
  assign frame_start = fs_q;
endmodule

// File: rtl/t1eb_top.sv
module t1eb_top
  import t1eb_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          PREFILL = 8,
  parameter int          MF_LEN  = 12,
  parameter logic [MF_LEN-1:0] FBIT_PAT = 12'b1000_1101_1100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_wr_en,
  input  logic tx_wr_bit,
  input  logic tx_line_en,
  output logic tx_line_bit,
  output logic tx_line_valid,
  output logic tx_frame_start,
  input  logic rx_line_en,
  input  logic rx_line_bit,
  input  logic rx_line_fbit,
  input  logic rx_rd_en,
  output logic rx_bit,
  output logic rx_valid,
  output logic tx_ovf,
  output logic tx_unf,
  output logic rx_ovf,
  output logic rx_unf,
  output logic slip_sticky
);
  logic [1:0]  rsync_q;
  logic        rst_i;
  elastic_ev_t tx_ev, rx_ev;
  logic        tx_fbit, tx_primed, tx_empty, tx_rd;
  logic        rx_fifo_bit, rx_primed, rx_empty, rx_wr, rx_take;
  logic        rx_bit_d, rx_val_d, slip_d;
  logic        rx_bit_q, rx_val_q, slip_q;
  elastic_ev_t tx_ev_q, rx_ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  t1eb_elastic #(.ADDR_W(ADDR_W), .PREFILL(PREFILL)) tx_fifo_i (
    .clk(clk), .rst_n(rst_i),
    .wr_en(tx_wr_en), .wr_bit(tx_wr_bit), .rd_en(tx_rd),
    .rd_bit(tx_fbit), .primed(tx_primed), .empty(tx_empty), .ev(tx_ev)
  );

  t1eb_tx_framer #(.DBITS(DATA_BITS), .MF_LEN(MF_LEN), .FPAT(FBIT_PAT)) framer_i (
    .clk(clk), .rst_n(rst_i), .line_en(tx_line_en),
    .fifo_primed(tx_primed), .fifo_empty(tx_empty), .fifo_bit(tx_fbit),
    .fifo_rd(tx_rd), .line_bit(tx_line_bit), .line_valid(tx_line_valid),
    .frame_start(tx_frame_start)
  );

  t1eb_elastic #(.ADDR_W(ADDR_W), .PREFILL(PREFILL)) rx_fifo_i (
    .clk(clk), .rst_n(rst_i),
    .wr_en(rx_wr), .wr_bit(rx_line_bit), .rd_en(rx_rd_en),
    .rd_bit(rx_fifo_bit), .primed(rx_primed), .empty(rx_empty), .ev(rx_ev)
  );

  always_comb begin
    rx_wr    = rx_line_en & ~rx_line_fbit;
    rx_take  = rx_rd_en & rx_primed & ~rx_empty;
    rx_val_d = rx_take;
    rx_bit_d = rx_take & rx_fifo_bit;
    slip_d   = slip_q | tx_ev.ovf | tx_ev.unf | rx_ev.ovf | rx_ev.unf;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rx_bit_q <= 1'b0;
      rx_val_q <= 1'b0;
      slip_q   <= 1'b0;
      tx_ev_q  <= '0;
      rx_ev_q  <= '0;
    end else begin
      rx_bit_q <= rx_bit_d;
      rx_val_q <= rx_val_d;
      slip_q   <= slip_d;
      tx_ev_q  <= tx_ev;
      rx_ev_q  <= rx_ev;
    end
  end

  assign rx_bit      = rx_bit_q;
  assign rx_valid    = rx_val_q;
  assign tx_ovf      = tx_ev_q.ovf;
  assign tx_unf      = tx_ev_q.unf;
  assign rx_ovf      = rx_ev_q.ovf;
  assign rx_unf      = rx_ev_q.unf;
  assign slip_sticky = slip_q;
endmodule

// File: rtl/t1eb_chk.sv
module t1eb_chk
  import t1eb_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tx_line_en,
  input logic tx_line_valid,
  input logic tx_frame_start,
  input logic rx_rd_en,
  input logic rx_valid,
  input logic tx_ovf,
  input logic tx_unf,
  input logic rx_ovf,
  input logic rx_unf,
  input logic slip_sticky
);
  logic [8:0] bits_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      seen_q <= 1'b0;
    end else if (tx_line_valid) begin
      seen_q <= 1'b1;
      bits_q <= tx_frame_start ? 9'd1 : bits_q + 9'd1;
    end
  end

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_frame_start && seen_q) |-> (bits_q == 9'(LINE_BITS)));
  // R2
  frame_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_line_valid && !tx_frame_start && seen_q) |-> (bits_q < 9'(LINE_BITS)));
  // R4
  first_bit_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_line_valid && !seen_q) |-> tx_frame_start);
  // R2
  fs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_start |-> tx_line_valid);
  // R2
  line_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_line_valid |-> $past(tx_line_en));
  // R6
  rx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_rd_en));
  // R10
  slip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf || tx_unf || rx_ovf || rx_unf) |-> slip_sticky);
  // R10
  slip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_sticky |=> slip_sticky);
  // R11
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ovf && tx_unf));
  // R11
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ovf && rx_unf));
endmodule

bind t1eb_top t1eb_chk chk_i (.*);

// File: tb/t1eb_top_tb_top.sv
`timescale 1ns/1ps
module t1eb_top_tb_top;
  localparam int ADDR_W  = 4;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PREFILL = 8;
  localparam int MF      = 12;
  localparam int LBITS   = 193;
  localparam logic [11:0] FPAT = 12'b1000_1101_1100;
  localparam int TOTAL   = 16600;
  localparam int RST2    = 16000;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_wr_en, tx_wr_bit, tx_line_en;
  logic rx_line_en, rx_line_bit, rx_line_fbit, rx_rd_en;
  logic tx_line_bit, tx_line_valid, tx_frame_start;
  logic rx_bit, rx_valid, tx_ovf, tx_unf, rx_ovf, rx_unf, slip_sticky;

  always #2 clk = ~clk;

  t1eb_top #(.ADDR_W(ADDR_W), .PREFILL(PREFILL), .MF_LEN(MF), .FBIT_PAT(FPAT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_wr_en(tx_wr_en), .tx_wr_bit(tx_wr_bit), .tx_line_en(tx_line_en),
    .tx_line_bit(tx_line_bit), .tx_line_valid(tx_line_valid),
    .tx_frame_start(tx_frame_start),
    .rx_line_en(rx_line_en), .rx_line_bit(rx_line_bit),
    .rx_line_fbit(rx_line_fbit), .rx_rd_en(rx_rd_en),
    .rx_bit(rx_bit), .rx_valid(rx_valid),
    .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf),
    .slip_sticky(slip_sticky)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // behavioural model: index 0 = transmit store, 1 = receive store
  bit q[2][$];
  bit prm[2];
  bit started;
  int pos, fidx;
  bit e_tx_bit, e_tx_val, e_fs, e_rx_bit, e_rx_val;
  bit e_tx_ovf, e_tx_unf, e_rx_ovf, e_rx_unf, e_slip;

  task automatic store_step(input int s, input bit wr, input bit wb, input bit rd,
                            output bit ovf, output bit unf);
    bit dord;
    dord = rd && prm[s] && (q[s].size() > 0);
    unf  = rd && prm[s] && (q[s].size() == 0);
    ovf  = wr && (q[s].size() == DEPTH) && !dord;
    if (dord) void'(q[s].pop_front());
    if (ovf) begin
      while (q[s].size() > PREFILL) void'(q[s].pop_front());
    end else if (wr) begin
      q[s].push_back(wb);
    end
    if (unf) prm[s] = 1'b0;
    else if (q[s].size() >= PREFILL) prm[s] = 1'b1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q[0].delete(); q[1].delete();
      prm[0] = 0; prm[1] = 0;
      started = 0; pos = 0; fidx = 0;
      {e_tx_bit, e_tx_val, e_fs, e_rx_bit, e_rx_val} = '0;
      {e_tx_ovf, e_tx_unf, e_rx_ovf, e_rx_unf, e_slip} = '0;
    end else begin
      bit emit, isf, ok, ok_r;
      emit = tx_line_en && (started || prm[0]);
      isf  = (pos == 0);
      ok   = prm[0] && (q[0].size() > 0);
      e_tx_val = emit;
      e_fs     = emit && isf;
      if (!emit)     e_tx_bit = 0;
      else if (isf)  e_tx_bit = FPAT[fidx];
      else           e_tx_bit = ok ? q[0][0] : 1'b1;
      ok_r     = prm[1] && (q[1].size() > 0);
      e_rx_val = rx_rd_en && ok_r;
      e_rx_bit = e_rx_val && q[1][0];
      store_step(0, tx_wr_en, tx_wr_bit, emit && !isf, e_tx_ovf, e_tx_unf);
      store_step(1, rx_line_en && !rx_line_fbit, rx_line_bit, rx_rd_en, e_rx_ovf, e_rx_unf);
      if (emit) begin
        started = 1;
        if (isf) fidx = (fidx + 1) % MF;
        pos = (pos + 1) % LBITS;
      end
      e_slip = e_slip | e_tx_ovf | e_tx_unf | e_rx_ovf | e_rx_unf;
    end
  end

  task automatic chk(input string tag, input string nm, input logic act, input bit exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit rs;
    rs = !rst_n;
    vectors++;
    chk(rs ? "R1" : "R4",        "tx_line_valid",  tx_line_valid,  e_tx_val);
    chk(rs ? "R1" : "R2/R3/R5",  "tx_line_bit",    tx_line_bit,    e_tx_bit);
    chk(rs ? "R1" : "R2",        "tx_frame_start", tx_frame_start, e_fs);
    chk(rs ? "R1" : "R7",        "rx_valid",       rx_valid,       e_rx_val);
    chk(rs ? "R1" : "R6",        "rx_bit",         rx_bit,         e_rx_bit);
    chk(rs ? "R1" : "R8/R11",    "tx_ovf",         tx_ovf,         e_tx_ovf);
    chk(rs ? "R1" : "R9/R11",    "tx_unf",         tx_unf,         e_tx_unf);
    chk(rs ? "R1" : "R8",        "rx_ovf",         rx_ovf,         e_rx_ovf);
    chk(rs ? "R1" : "R9",        "rx_unf",         rx_unf,         e_rx_unf);
    chk(rs ? "R1" : "R10",       "slip_sticky",    slip_sticky,    e_slip);
  endtask

  bit [31:0] rng = 32'h1234_5678;
  int tx_acc, rd_acc, rx_cnt;
  bit jit;

  task automatic drive(input int c);
    bit quiet;
    int p;
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    rst_n = !((c < 5) || (c >= RST2 && c < RST2 + 5));
    quiet = (c < 12) || (c >= RST2 && c < RST2 + 12);
    {tx_wr_en, tx_line_en, rx_line_en, rx_line_fbit, rx_rd_en} = '0;
    tx_wr_bit   = rng[20];
    rx_line_bit = rng[21];
    p = c % 4;
    if (quiet) return;
    if ((c >= 6000 && c < 8000)) begin
      // write-heavy: overflow (R8)
      tx_wr_en     = rng[2:0] < 6;
      tx_line_en   = rng[5:3] < 2;
      rx_line_en   = rng[8:6] < 6;
      rx_line_fbit = rng[12:9] == 0;
      rx_rd_en     = rng[15:13] < 2;
    end else if (c >= 8000 && c < 10000) begin
      // read-heavy: underflow (R9), reads during prefill (R7)
      tx_wr_en     = rng[2:0] < 2;
      tx_line_en   = rng[5:3] < 6;
      rx_line_en   = rng[8:6] < 2;
      rx_line_fbit = rng[12:9] == 0;
      rx_rd_en     = rng[15:13] < 6;
    end else if (c >= 10000 && c < 14000) begin
      // balanced dense: coincident read/write at limits (R11)
      tx_wr_en     = rng[2:0] < 4;
      tx_line_en   = rng[5:3] < 4;
      rx_line_en   = rng[8:6] < 4;
      rx_line_fbit = rng[12:9] == 0;
      rx_rd_en     = rng[15:13] < 4;
    end else begin
      // nominal line rates with framing bit (R2, R3, R6) and rx jitter
      if (p == 0) begin
        tx_line_en = 1;
        jit = rng[0];
      end
      if (p == 2) begin
        tx_acc += 192;
        if (tx_acc >= 193) begin tx_acc -= 193; tx_wr_en = 1; end
      end
      if (p == (jit ? 2 : 1)) begin
        rx_line_en   = 1;
        rx_line_fbit = (rx_cnt % 193) == 0;
        rx_cnt++;
      end
      if (p == 3) begin
        rd_acc += 192;
        if (rd_acc >= 193) begin rd_acc -= 193; rx_rd_en = 1; end
      end
    end
  endtask

  initial begin
    rst_n = 0;
    {tx_wr_en, tx_wr_bit, tx_line_en, rx_line_en, rx_line_bit, rx_line_fbit, rx_rd_en} = '0;
    tx_acc = 0; rd_acc = 0; rx_cnt = 0; jit = 0;
    for (int c = 0; c < TOTAL; c++) begin
      @(negedge clk);
      if (c > 1) compare();
      drive(c);
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule